// File: doc/BRIEF.md
# USB Line-State Control Unit

This unit sits between a host-side USB serial engine and the transceiver pads. It holds a small control word written by the CPU, and from that word it decides what reaches the D+ and D− drivers. In normal operation the serial engine's transmit data and driver enable pass through unchanged. A two-bit override field can instead hold the bus in single-ended zero (bus reset), in J or in K, and keeps the driver enabled while it does so. A polarity bit swaps the two lines when a low-speed device is wired straight to the port. A speed bit tells the rest of the host which signalling rate is in use. When the low-speed device sits behind a hub, both the speed bit and the swap bit stay clear.

A suspend bit in the same word turns the driver off and puts the data RAM into its sleep state. It also drops the clock-run enable that gates the internal clocks. The unit leaves suspend without help from the CPU in two cases. The first is when the received line state stays away from the idle J of the selected speed for a set number of synchronised samples. The second is when the CPU performs a data write cycle. On wake the suspend bit clears and the unit sends a single-cycle resume pulse to the interrupt logic.

Top module: `usb_line_ctrl`

## Requirements
- R1: After synchronous reset the override field is 00, the speed, swap and suspend bits are 0, ram_sleep is 0, clk_run is 1 and resume_pulse is 0.
- R2: With override 00 and not suspended, drv_dp, drv_dm and drv_oe follow tx_dp, tx_dm and tx_oe (after the swap of R6) in the same cycle.
- R3: With override 01 and not suspended, both drv_dp and drv_dm are 0 and drv_oe is 1, whatever the transmit inputs are.
- R4: With override 10 and not suspended, the line pair shows J (D+ 1, D− 0 before the swap) with drv_oe 1.
- R5: With override 11 and not suspended, the line pair shows K (D+ 0, D− 1 before the swap) with drv_oe 1.
- R6: When the swap bit is 1, drv_dp and drv_dm trade places in every mode; SE0 stays SE0.
- R7: speed_low reflects the speed bit: 0 selects full speed, 1 selects low speed.
- R8: While the suspend bit is 1, drv_oe, drv_dp and drv_dm are 0, ram_sleep is 1 and clk_run is 0, whatever the override field and the transmit inputs are.
- R9: While suspended, a received line state that differs from idle J ({rx_dp,rx_dm} = 10 at full speed, 01 at low speed) wakes the unit once WAKE_FILT consecutive synchronised samples show it. The suspend bit clears at clock edge SYNC_STAGES+WAKE_FILT after the first active sample is presented, and a burst one sample shorter is ignored.
- R10: While suspended, a data_wr cycle clears the suspend bit at the next clock edge.
- R11: Each wake raises resume_pulse for exactly one cycle: the cycle in which ram_sleep has just fallen.
- R12: If reg_wr coincides with a wake event, the written word is loaded and resume_pulse stays 0.
- R13: When not suspended, data_wr and bus activity change neither the control word nor resume_pulse.
- R14: reg_wdata loads as: bits 1:0 override, bit 2 speed, bit 3 swap, bit 4 suspend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 5 | Control word (layout in R14) |
| data_wr | input | 1 | CPU data write cycle (wake source) |
| tx_dp | input | 1 | Serial engine D+ data |
| tx_dm | input | 1 | Serial engine D− data |
| tx_oe | input | 1 | Serial engine driver enable |
| rx_dp | input | 1 | Received D+ (asynchronous) |
| rx_dm | input | 1 | Received D− (asynchronous) |
| drv_dp | output | 1 | D+ to the transceiver |
| drv_dm | output | 1 | D− to the transceiver |
| drv_oe | output | 1 | Transceiver driver enable |
| speed_low | output | 1 | 1 when low speed is selected |
| ram_sleep | output | 1 | Data RAM suspend request |
| clk_run | output | 1 | Internal clock enable, low in suspend |
| resume_pulse | output | 1 | One-cycle wake indication |

## Verification
The bench builds the unit with SYNC_STAGES = 2 and WAKE_FILT = 3. With a filter that short, a burst of two active samples, which must be ignored, and a burst of three, which must wake, each take only a few cycles to drive. The exact wake edge can then be pinned down against the synchroniser delay. Low-speed idle is exercised as well, so that a full-speed J pattern counts as activity. A register write is placed in the same cycle as a data-write wake.

// File: rtl/usb_lsc_pkg.sv
// Package: shared types for the USB line-state control unit.
// Assumes the control word layout is fixed at five bits (see CTL_W).
package usb_lsc_pkg;

    // Override field encodings; the values are decoded by the line mux.
    typedef enum logic [1:0] {
        FM_NORMAL = 2'b00,
        FM_SE0    = 2'b01,
        FM_J      = 2'b10,
        FM_K      = 2'b11
    } force_mode_t;

    // Control word: packed MSB first, suspend at bit 4, override at bits 1:0.
    typedef struct packed {
        logic        susp;
        logic        swap;
        logic        low_spd;
        force_mode_t force_md;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Pair of line levels, D+ first.
    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

    localparam line_t LINE_FS_J = '{dp: 1'b1, dm: 1'b0};
    localparam line_t LINE_LS_J = '{dp: 1'b0, dm: 1'b1};

    // Idle J level on the wire for the selected speed.
    function automatic line_t idle_j(input logic low_spd);
        return low_spd ? LINE_LS_J : LINE_FS_J;
    endfunction

endpackage

// File: rtl/lsc_wake_det.sv
// Module: bus-activity wake detector.
// Synchronises the received line pair through SYNC_STAGES flops, then counts
// consecutive samples that differ from idle J. Raises wake_hit in the cycle
// whose edge would complete WAKE_FILT samples. Counting only runs while armed.
// Assumes: rx inputs are asynchronous; WAKE_FILT >= 1, SYNC_STAGES >= 1.
module lsc_wake_det
    import usb_lsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_FILT   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_dp,
    input  logic rx_dm,
    input  logic armed,
    input  logic low_spd,
    output logic wake_hit
);

    localparam int CNT_W = $clog2(WAKE_FILT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAKE_FILT - 1);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(WAKE_FILT);

    line_t            stg [SYNC_STAGES];
    line_t            line_s;
    logic             active;
    logic [CNT_W-1:0] run_cnt;

    // Synchroniser chain, reset to full-speed idle.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= LINE_FS_J;
                else        stg[g] <= '{dp: rx_dp, dm: rx_dm};
            end
        end else begin : g_next
            // Later stages follow the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= LINE_FS_J;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign line_s = stg[SYNC_STAGES-1];

    // Any state other than idle J counts as activity.
    assign active = armed && (line_s != idle_j(low_spd));

    // Run-length counter of consecutive active samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) run_cnt <= '0;
        else if (run_cnt != SAT_CNT) run_cnt <= run_cnt + 1'b1;
    end

    assign wake_hit = active && (run_cnt == LAST_CNT);

endmodule

// File: rtl/lsc_ctrl_reg.sv
// Module: control word register with suspend/wake sequencing.
// Loads the word on reg_wr. While suspended, a data write or a bus wake
// clears the suspend bit and raises resume_pulse for one cycle. A register
// write in the same cycle takes precedence and suppresses the pulse.
// Assumes: reg_wr and wake sources are synchronous to clk.
module lsc_ctrl_reg
    import usb_lsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    input  logic             data_wr,
    input  logic             bus_wake,
    output ctl_t             ctl_q,
    output logic             resume_pulse
);

    logic wake_ev;

    // A wake needs the unit to be in suspend.
    assign wake_ev = ctl_q.susp && (data_wr || bus_wake);

    // Control word update: write first, then wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{susp: 1'b0, swap: 1'b0, low_spd: 1'b0, force_md: FM_NORMAL};
        end else if (reg_wr) begin
            ctl_q <= ctl_t'(reg_wdata);
        end else if (wake_ev) begin
            ctl_q.susp <= 1'b0;
        end
    end

    // One-cycle resume indication following a wake.
    always_ff @(posedge clk) begin
        if (!rst_n) resume_pulse <= 1'b0;
        else        resume_pulse <= wake_ev && !reg_wr;
    end

endmodule

// File: rtl/lsc_line_mux.sv
// Module: transceiver output selection.
// Chooses between pass-through transmit data and a forced line state, applies
// the optional D+/D- swap, and silences the driver in suspend.
// Assumes: purely combinational; the caller registers nothing after it.
module lsc_line_mux
    import usb_lsc_pkg::*;
(
    input  ctl_t ctl,
    input  logic tx_dp,
    input  logic tx_dm,
    input  logic tx_oe,
    output logic drv_dp,
    output logic drv_dm,
    output logic drv_oe
);

    line_t pick;
    logic  pick_oe;
    line_t wire_lv;

    // Select pass-through or forced state.
    always_comb begin
        unique case (ctl.force_md)
            FM_NORMAL: begin pick = '{dp: tx_dp, dm: tx_dm}; pick_oe = tx_oe; end
            FM_SE0:    begin pick = '{dp: 1'b0,  dm: 1'b0};  pick_oe = 1'b1;  end
            FM_J:      begin pick = LINE_FS_J;               pick_oe = 1'b1;  end
            FM_K:      begin pick = LINE_LS_J;               pick_oe = 1'b1;  end
            default:   begin pick = '{dp: 1'b0,  dm: 1'b0};  pick_oe = 1'b0;  end
        endcase
    end

    // Optional polarity swap for direct low-speed attach.
    always_comb begin
        if (ctl.swap) wire_lv = '{dp: pick.dm, dm: pick.dp};
        else          wire_lv = pick;
    end

    // Suspend gates the driver and parks both lines low.
    always_comb begin
        if (ctl.susp) begin
            drv_dp = 1'b0;
            drv_dm = 1'b0;
            drv_oe = 1'b0;
        end else begin
            drv_dp = wire_lv.dp;
            drv_dm = wire_lv.dm;
            drv_oe = pick_oe;
        end
    end

endmodule

// File: rtl/usb_line_ctrl.sv
// Module: top of the USB line-state control unit.
// Ties the control register, bus wake detector and output mux together and
// exposes the suspend-derived power controls.
// Assumes: single clock domain apart from the rx pins.
module usb_line_ctrl
    import usb_lsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_FILT   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    input  logic             data_wr,
    input  logic             tx_dp,
    input  logic             tx_dm,
    input  logic             tx_oe,
    input  logic             rx_dp,
    input  logic             rx_dm,
    output logic             drv_dp,
    output logic             drv_dm,
    output logic             drv_oe,
    output logic             speed_low,
    output logic             ram_sleep,
    output logic             clk_run,
    output logic             resume_pulse
);

    ctl_t        ctl_q;
    logic        bus_wake;
    force_mode_t force_sel;

    lsc_ctrl_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .data_wr      (data_wr),
        .bus_wake     (bus_wake),
        .ctl_q        (ctl_q),
        .resume_pulse (resume_pulse)
    );

    lsc_wake_det #(
        .SYNC_STAGES (SYNC_STAGES),
        .WAKE_FILT   (WAKE_FILT)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_dp    (rx_dp),
        .rx_dm    (rx_dm),
        .armed    (ctl_q.susp),
        .low_spd  (ctl_q.low_spd),
        .wake_hit (bus_wake)
    );

    lsc_line_mux u_mux (
        .ctl    (ctl_q),
        .tx_dp  (tx_dp),
        .tx_dm  (tx_dm),
        .tx_oe  (tx_oe),
        .drv_dp (drv_dp),
        .drv_dm (drv_dm),
        .drv_oe (drv_oe)
    );

    // Power controls and speed indication straight from the word.
    assign force_sel = ctl_q.force_md;
    assign speed_low = ctl_q.low_spd;
    assign ram_sleep = ctl_q.susp;
    assign clk_run   = !ctl_q.susp;

endmodule

// File: rtl/lsc_checker.sv
// Module: property checker for usb_line_ctrl, attached by bind.
module lsc_checker
    import usb_lsc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        data_wr,
    input logic        drv_dp,
    input logic        drv_dm,
    input logic        drv_oe,
    input logic        ram_sleep,
    input logic        resume_pulse,
    input force_mode_t force_sel
);

    a_r8_quiet_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sleep |-> (!drv_oe && !drv_dp && !drv_dm));

    a_r3_se0_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sleep && force_sel == FM_SE0) |-> (drv_oe && !drv_dp && !drv_dm));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    a_r11_pulse_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (!ram_sleep && $past(ram_sleep)));

    a_r10_data_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sleep && data_wr && !reg_wr) |=> (!ram_sleep && resume_pulse));

    a_r13_no_pulse_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sleep |=> !resume_pulse);

endmodule

bind usb_line_ctrl lsc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .data_wr      (data_wr),
    .drv_dp       (drv_dp),
    .drv_dm       (drv_dm),
    .drv_oe       (drv_oe),
    .ram_sleep    (ram_sleep),
    .resume_pulse (resume_pulse),
    .force_sel    (force_sel)
);

// File: tb/tb_usb_line_ctrl.sv
// Bench: behavioural reference model compared on every clock.
module tb_usb_line_ctrl;

    localparam int SYNC = 2;
    localparam int FILT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic       data_wr = 1'b0;
    logic       tx_dp = 1'b0, tx_dm = 1'b0, tx_oe = 1'b0;
    logic       rx_dp = 1'b1, rx_dm = 1'b0;
    logic       drv_dp, drv_dm, drv_oe, speed_low, ram_sleep, clk_run, resume_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    usb_line_ctrl #(.SYNC_STAGES(SYNC), .WAKE_FILT(FILT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .data_wr(data_wr), .tx_dp(tx_dp), .tx_dm(tx_dm), .tx_oe(tx_oe),
        .rx_dp(rx_dp), .rx_dm(rx_dm), .drv_dp(drv_dp), .drv_dm(drv_dm),
        .drv_oe(drv_oe), .speed_low(speed_low), .ram_sleep(ram_sleep),
        .clk_run(clk_run), .resume_pulse(resume_pulse)
    );

    // Reference model state.
    int       m_force = 0;
    bit       m_ls = 0, m_inv = 0, m_susp = 0, m_pulse = 0;
    int       m_run = 0;
    bit [1:0] m_sync[$];

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_force = 0; m_ls = 0; m_inv = 0; m_susp = 0; m_pulse = 0; m_run = 0;
            m_sync.delete();
            for (int i = 0; i < SYNC; i++) m_sync.push_back(2'b10);
        end else begin
            bit [1:0] idle;
            bit act, wake;
            idle = m_ls ? 2'b01 : 2'b10;
            act  = m_susp && (m_sync[0] != idle);
            wake = m_susp && (data_wr || (act && m_run == FILT - 1));
            m_run = act ? ((m_run < FILT) ? m_run + 1 : FILT) : 0;
            if (reg_wr) begin
                m_force = int'(reg_wdata[1:0]);
                m_ls = reg_wdata[2]; m_inv = reg_wdata[3]; m_susp = reg_wdata[4];
                m_pulse = 0;
            end else if (wake) begin
                m_susp = 0; m_pulse = 1;
            end else begin
                m_pulse = 0;
            end
            void'(m_sync.pop_front());
            m_sync.push_back({rx_dp, rx_dm});
        end
    end

    task automatic chk(string name, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit ep, em, eo, t;
            if (m_susp) begin
                ep = 0; em = 0; eo = 0;
            end else begin
                case (m_force)
                    0: begin ep = tx_dp; em = tx_dm; eo = tx_oe; end
                    1: begin ep = 0; em = 0; eo = 1; end
                    2: begin ep = 1; em = 0; eo = 1; end
                    default: begin ep = 0; em = 1; eo = 1; end
                endcase
                if (m_inv) begin t = ep; ep = em; em = t; end
            end
            chk("drv_dp", drv_dp, ep);
            chk("drv_dm", drv_dm, em);
            chk("drv_oe", drv_oe, eo);
            chk("speed_low", speed_low, m_ls);
            chk("ram_sleep", ram_sleep, m_susp);
            chk("clk_run", clk_run, !m_susp);
            chk("resume_pulse", resume_pulse, m_pulse);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Word layout per R14: {susp, swap, speed, override[1:0]}.
    task automatic wr_ctl(bit [1:0] fm, bit ls, bit inv, bit sp);
        reg_wdata = {sp, inv, ls, fm};
        reg_wr = 1;
        step(1);
        reg_wr = 0;
    endtask

    task automatic tx_sweep();
        for (int i = 0; i < 8; i++) begin
            {tx_dp, tx_dm, tx_oe} = 3'(i);
            step(1);
        end
    endtask

    task automatic rx_burst(bit [1:0] lv, bit [1:0] idle, int n);
        {rx_dp, rx_dm} = lv;
        step(n);
        {rx_dp, rx_dm} = idle;
    endtask

    initial begin
        cur_req = "R1"; step(3); rst_n = 1; step(3);
        cur_req = "R2"; tx_sweep();
        cur_req = "R7"; wr_ctl(2'b00, 1, 0, 0); tx_sweep(); wr_ctl(2'b00, 0, 0, 0);
        cur_req = "R3"; wr_ctl(2'b01, 0, 0, 0); tx_sweep();
        cur_req = "R4"; wr_ctl(2'b10, 0, 0, 0); tx_sweep();
        cur_req = "R5"; wr_ctl(2'b11, 0, 0, 0); tx_sweep();
        cur_req = "R6";
        for (int f = 0; f < 4; f++) begin wr_ctl(2'(f), 1, 1, 0); tx_sweep(); end
        cur_req = "R8"; wr_ctl(2'b11, 0, 0, 1); tx_sweep();
        cur_req = "R10"; data_wr = 1; step(1); data_wr = 0;
        cur_req = "R11"; step(3);
        cur_req = "R9";
        wr_ctl(2'b00, 0, 0, 1); step(2);
        rx_burst(2'b01, 2'b10, FILT - 1); step(8);
        rx_burst(2'b00, 2'b10, FILT); step(8);
        cur_req = "R9 low speed";
        wr_ctl(2'b00, 1, 1, 0); {rx_dp, rx_dm} = 2'b01; step(4);
        wr_ctl(2'b00, 1, 1, 1); step(4);
        rx_burst(2'b10, 2'b01, FILT + 2); step(8);
        cur_req = "R12";
        wr_ctl(2'b00, 0, 0, 1); {rx_dp, rx_dm} = 2'b10; step(3);
        reg_wdata = 5'b10110; reg_wr = 1; data_wr = 1; step(1);
        reg_wr = 0; data_wr = 0; step(3);
        reg_wdata = 5'b00101; reg_wr = 1; data_wr = 1; step(1);
        reg_wr = 0; data_wr = 0; step(3);
        cur_req = "R13";
        wr_ctl(2'b00, 0, 0, 0);
        data_wr = 1; step(3); data_wr = 0;
        rx_burst(2'b01, 2'b10, FILT + 3); step(6);
        cur_req = "R14"; wr_ctl(2'b10, 1, 1, 0); tx_sweep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hang is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule